// File: doc/BRIEF.md
# Dual ALU Pipeline Hazard Control

This block is the decode-stage hazard and placement controller for a five-stage in-order pipeline that has two arithmetic units. The early unit sits in stage 3 and the late unit sits in stage 4, next to data memory. For each decoded instruction the block makes three decisions:

- **Placement.** It picks which unit an arithmetic instruction executes in.
- **Stall.** It decides whether the instruction must wait one cycle in decode.
- **Operand source.** It picks where each source operand is taken from: the register file, or one of three forwarding paths.

Only instructions reading a value that neither placement nor forwarding can deliver in time are held back. Anything that can be rescued by moving the work to the late unit proceeds.

The block tracks the in-flight instructions itself. It keeps a three-deep record of each accepted instruction's class, destination, write enable and late-unit flag, covering stage 3, stage 4 and write-back. It exposes the late-unit flag of the stage-3 and stage-4 instructions so the datapath can steer them.

Decode input follows a valid/ready handshake. An instruction is taken when `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, the upstream stage must hold the same instruction on the decode inputs. Each cycle without an accepted instruction inserts a bubble into stage 3.

Top module: `dual_alu_hazard_ctl`

## Requirements
- R1: After reset the pipeline holds only bubbles: `stall`, `dec_alu2`, `ex1_alu2` and `ex2_alu2` are 0, `dec_ready` is 1, and both operand selects read the register file (00).
- R2: Class codes on `dec_cls` are: 0 none, 1 register ALU, 2 immediate ALU, 3 load, 4 store, 5 conditional branch, 6 register jump, 7 register jump-and-link, 8 jump, 9 jump-and-link. The destination and its write enable depend on the class:
  - Register ALU writes `dec_rd`.
  - Immediate ALU and load write `dec_rt`.
  - Both link classes (7 and 9) write register 31.
  - The ALU and load classes write only when their destination is nonzero.
  - All other classes write nothing.
- R3: `dec_rs` is a source for classes 1 through 7. `dec_rt` is a source only for classes 1 and 4. An operand that is not read selects the register file.
- R4: `dec_alu2` is 1 for an accepted class 1 or 2 instruction that reads a register written by the stage-3 instruction. The flag is never set together with `stall`.
- R5: Loads and stores never get `dec_alu2`; their address always uses the early unit.
- R6: `stall` is 1 when the decode instruction reads a register written by a stage-3 load or by a stage-3 late-unit instruction. This covers a store's data operand.
- R7: A dependency on a stage-3 early-unit producer, on any stage-4 or write-back producer, or on register 0 does not stall. A load whose target is register 0 creates no dependency.
- R8: The operand select codes are 00 register file, 01 stage 3, 10 stage 4 and 11 write-back. When several in-flight writers match a source, the youngest writer wins.
- R9: `dec_ready` equals the inverse of `stall`. On a stall the decode instruction is held and stage 3 receives a bubble, which has no write and a late-unit flag of 0.
- R10: The late-unit flag of an accepted instruction appears on `ex1_alu2` one cycle later and on `ex2_alu2` two cycles later.
- R11: With `dec_valid` low the block neither stalls nor sets `dec_alu2`, both selects are 00, and a bubble enters stage 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode instruction present |
| dec_ready | output | 1 | Decode instruction accepted this cycle |
| dec_cls | input | 4 | Opcode class of the decode instruction |
| dec_rs | input | REG_W | First source register field |
| dec_rt | input | REG_W | Second source / immediate-form destination field |
| dec_rd | input | REG_W | Register-form destination field |
| stall | output | 1 | Hold decode, bubble into stage 3 |
| dec_alu2 | output | 1 | Decode instruction executes in the late unit |
| sel_a | output | 2 | Source select for the rs operand |
| sel_b | output | 2 | Source select for the rt operand |
| ex1_alu2 | output | 1 | Late-unit flag of the stage-3 instruction |
| ex2_alu2 | output | 1 | Late-unit flag of the stage-4 instruction |

## Verification
The embedded properties make three assumptions about the inputs:
- Reset is held high through the first clock edge, so the pipelined flags are known before any history comparison.
- `dec_cls` carries only the ten defined codes.
- Upstream keeps the same instruction on the decode inputs while `dec_ready` is low.

The stimulus is a directed instruction stream that uses only those codes and repeats the held instruction on every stall cycle. Reset is asserted from time zero. The stream exercises:
- load-use and late-unit-use hazards;
- early-unit producers forcing late placement;
- write-back and stage-4 forwarding;
- triple-writer priority;
- register 0 targets;
- link-register writes;
- idle cycles.

// File: rtl/dah_pkg.sv
package dah_pkg;

  typedef enum logic [3:0] {
    OPC_NONE  = 4'd0,
    OPC_ALU   = 4'd1,
    OPC_ALUI  = 4'd2,
    OPC_LOAD  = 4'd3,
    OPC_STORE = 4'd4,
    OPC_BRZ   = 4'd5,
    OPC_JR    = 4'd6,
    OPC_JALR  = 4'd7,
    OPC_J     = 4'd8,
    OPC_JAL   = 4'd9
  } op_class_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EX1 = 2'b01,
    SRC_EX2 = 2'b10,
    SRC_WB  = 2'b11
  } src_sel_e;

endpackage

// File: rtl/dah_field_decode.sv
module dah_field_decode
  import dah_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             valid,
  input  op_class_e        cls,
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic             rd_rs,
  output logic             rd_rt,
  output logic [REG_W-1:0] wdst,
  output logic             wen,
  output logic             arith
);

  localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

  always_comb begin
    rd_rs = 1'b0;
    rd_rt = 1'b0;
    wdst  = '0;
    arith = 1'b0;
    unique case (cls)
      OPC_ALU:   begin rd_rs = 1'b1; rd_rt = 1'b1; wdst = rd; arith = 1'b1; end
      OPC_ALUI:  begin rd_rs = 1'b1; wdst = rt; arith = 1'b1; end
      OPC_LOAD:  begin rd_rs = 1'b1; wdst = rt; end
      OPC_STORE: begin rd_rs = 1'b1; rd_rt = 1'b1; end
      OPC_BRZ:   rd_rs = 1'b1;
      OPC_JR:    rd_rs = 1'b1;
      OPC_JALR:  begin rd_rs = 1'b1; wdst = LINK_REG; end
      OPC_JAL:   wdst = LINK_REG;
      default:   ;
    endcase
    rd_rs = rd_rs & valid;
    rd_rt = rd_rt & valid;
    arith = arith & valid;
    wen   = valid && (wdst != '0);
  end

endmodule

// File: rtl/dah_fwd_sel.sv
module dah_fwd_sel
  import dah_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             used,
  input  logic [REG_W-1:0] src,
  input  logic             ex1_wen,
  input  logic [REG_W-1:0] ex1_dst,
  input  logic             ex2_wen,
  input  logic [REG_W-1:0] ex2_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output src_sel_e         sel
);

  logic live;
  assign live = used && (src != '0);

  always_comb begin
    sel = SRC_RF;
    if (live) begin
      if (ex1_wen && (ex1_dst == src))      sel = SRC_EX1;
      else if (ex2_wen && (ex2_dst == src)) sel = SRC_EX2;
      else if (wb_wen && (wb_dst == src))   sel = SRC_WB;
    end
  end

endmodule

// File: rtl/dah_stage_pipe.sv
module dah_stage_pipe
  import dah_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  op_class_e        in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_wen,
  input  logic             in_late,
  output op_class_e        st_cls  [STAGES],
  output logic [REG_W-1:0] st_dst  [STAGES],
  output logic             st_wen  [STAGES],
  output logic             st_late [STAGES]
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    op_class_e        nxt_cls;
    logic [REG_W-1:0] nxt_dst;
    logic             nxt_wen;
    logic             nxt_late;

    if (s == 0) begin : g_head
      assign nxt_cls  = in_cls;
      assign nxt_dst  = in_dst;
      assign nxt_wen  = in_wen;
      assign nxt_late = in_late;
    end else begin : g_tail
      assign nxt_cls  = st_cls[s-1];
      assign nxt_dst  = st_dst[s-1];
      assign nxt_wen  = st_wen[s-1];
      assign nxt_late = st_late[s-1];

      assert_late_flag_follows_R10: assert property (@(posedge clk) disable iff (rst)
        st_late[s] == $past(st_late[s-1]));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_cls[s]  <= OPC_NONE;
        st_dst[s]  <= '0;
        st_wen[s]  <= 1'b0;
        st_late[s] <= 1'b0;
      end else begin
        st_cls[s]  <= nxt_cls;
        st_dst[s]  <= nxt_dst;
        st_wen[s]  <= nxt_wen;
        st_late[s] <= nxt_late;
      end
    end
  end

endmodule

// File: rtl/dual_alu_hazard_ctl.sv
module dual_alu_hazard_ctl
  import dah_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic [3:0]       dec_cls,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic [REG_W-1:0] dec_rd,
  output logic             stall,
  output logic             dec_alu2,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             ex1_alu2,
  output logic             ex2_alu2
);

  localparam int STAGES = 3;
  localparam int ST_EX1 = 0;
  localparam int ST_EX2 = 1;
  localparam int ST_WB  = 2;
  localparam int N_OPS  = 2;

  op_class_e        cls;
  logic             use_rs, use_rt, wen, arith;
  logic [REG_W-1:0] wdst;

  op_class_e        st_cls  [STAGES];
  logic [REG_W-1:0] st_dst  [STAGES];
  logic             st_wen  [STAGES];
  logic             st_late [STAGES];

  logic [REG_W-1:0] op_src  [N_OPS];
  logic             op_used [N_OPS];
  src_sel_e         op_sel  [N_OPS];
  logic             op_ex1  [N_OPS];

  logic ex1_late_result, dep_ex1, accept;

  assign cls = op_class_e'(dec_cls);

  dah_field_decode #(.REG_W(REG_W)) u_decode (
    .valid (dec_valid),
    .cls   (cls),
    .rs    (dec_rs),
    .rt    (dec_rt),
    .rd    (dec_rd),
    .rd_rs (use_rs),
    .rd_rt (use_rt),
    .wdst  (wdst),
    .wen   (wen),
    .arith (arith)
  );

  assign op_src[0]  = dec_rs;
  assign op_src[1]  = dec_rt;
  assign op_used[0] = use_rs;
  assign op_used[1] = use_rt;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    dah_fwd_sel #(.REG_W(REG_W)) u_sel (
      .used    (op_used[k]),
      .src     (op_src[k]),
      .ex1_wen (st_wen[ST_EX1]),
      .ex1_dst (st_dst[ST_EX1]),
      .ex2_wen (st_wen[ST_EX2]),
      .ex2_dst (st_dst[ST_EX2]),
      .wb_wen  (st_wen[ST_WB]),
      .wb_dst  (st_dst[ST_WB]),
      .sel     (op_sel[k])
    );
    assign op_ex1[k] = (op_sel[k] == SRC_EX1);
  end

  // A stage-3 result that only exists at the end of stage 4 cannot be used
  // by either placement of the decode instruction.
  assign ex1_late_result = (st_cls[ST_EX1] == OPC_LOAD) || st_late[ST_EX1];
  assign dep_ex1         = op_ex1[0] || op_ex1[1];

  assign stall     = dep_ex1 && ex1_late_result;
  assign dec_ready = !stall;
  assign dec_alu2  = arith && dep_ex1 && !stall;
  assign accept    = dec_valid && !stall;

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  dah_stage_pipe #(.REG_W(REG_W), .STAGES(STAGES)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .in_cls  (accept ? cls : OPC_NONE),
    .in_dst  (accept ? wdst : '0),
    .in_wen  (accept && wen),
    .in_late (dec_alu2),
    .st_cls  (st_cls),
    .st_dst  (st_dst),
    .st_wen  (st_wen),
    .st_late (st_late)
  );

  assign ex1_alu2 = st_late[ST_EX1];
  assign ex2_alu2 = st_late[ST_EX2];

  assert_bubble_after_stall_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!st_wen[ST_EX1] && !st_late[ST_EX1] && st_cls[ST_EX1] == OPC_NONE));

  assert_late_only_arith_R5: assert property (@(posedge clk) disable iff (rst)
    dec_alu2 |-> (cls == OPC_ALU || cls == OPC_ALUI));

  assert_stall_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    stall |-> (dec_valid && st_wen[ST_EX1] &&
               (st_cls[ST_EX1] == OPC_LOAD || st_late[ST_EX1])));

  assert_no_late_with_stall_R4: assert property (@(posedge clk) disable iff (rst)
    !(stall && dec_alu2));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!stall && !dec_alu2 && sel_a == 2'b00 && sel_b == 2'b00));

endmodule

// File: tb/dual_alu_hazard_ctl_bench.sv
`timescale 1ns/1ps
module dual_alu_hazard_ctl_bench;

  localparam logic [3:0] C_NONE = 4'd0, C_ALU = 4'd1, C_ALUI = 4'd2, C_LOAD = 4'd3,
                         C_STORE = 4'd4, C_BRZ = 4'd5, C_JR = 4'd6, C_JAL = 4'd9;

  typedef struct {
    logic       st;
    logic       a2;
    logic [1:0] sa;
    logic [1:0] sb;
    logic       x1;
    logic       x2;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic       dec_ready;
  logic [3:0] dec_cls = '0;
  logic [4:0] dec_rs = '0, dec_rt = '0, dec_rd = '0;
  logic       stall, dec_alu2, ex1_alu2, ex2_alu2;
  logic [1:0] sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  dual_alu_hazard_ctl u_dual_alu_hazard_ctl (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_cls(dec_cls), .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd),
    .stall(stall), .dec_alu2(dec_alu2), .sel_a(sel_a), .sel_b(sel_b),
    .ex1_alu2(ex1_alu2), .ex2_alu2(ex2_alu2)
  );

  task automatic chk(input string what, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic [4:0] rs,
                      input logic [4:0] rt, input logic [4:0] rd,
                      input logic e_st, input logic e_a2, input logic [1:0] e_sa,
                      input logic [1:0] e_sb, input logic e_x1, input logic e_x2,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    dec_valid = v; dec_cls = c; dec_rs = rs; dec_rt = rt; dec_rd = rd;
    e.st = e_st; e.a2 = e_a2; e.sa = e_sa; e.sb = e_sb; e.x1 = e_x1; e.x2 = e_x2; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares the oldest expectation against the ports mid-cycle.
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("stall",    e.tag, int'(stall),     int'(e.st));
      chk("ready",    e.tag, int'(dec_ready), int'(!e.st));
      chk("dec_alu2", e.tag, int'(dec_alu2),  int'(e.a2));
      chk("sel_a",    e.tag, int'(sel_a),     int'(e.sa));
      chk("sel_b",    e.tag, int'(sel_b),     int'(e.sb));
      chk("ex1_alu2", e.tag, int'(ex1_alu2),  int'(e.x1));
      chk("ex2_alu2", e.tag, int'(ex2_alu2),  int'(e.x2));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step(0, C_NONE, 0, 0, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R1 R11 reset");
    step(1, C_ALU,  2, 3, 1,   0, 0, 2'b00, 2'b00, 0, 0, "R1 first ALU");
    step(1, C_LOAD, 1, 4, 0,   0, 0, 2'b01, 2'b00, 0, 0, "R5 R7 load base early fwd");
    step(1, C_ALU,  4, 6, 5,   1, 0, 2'b01, 2'b00, 0, 0, "R6 load-use stall");
    step(1, C_ALU,  4, 6, 5,   0, 0, 2'b10, 2'b00, 0, 0, "R9 held after bubble");
    step(1, C_ALU,  5, 8, 7,   0, 1, 2'b01, 2'b00, 0, 0, "R4 late placement");
    step(1, C_ALU,  7, 4, 10,  1, 0, 2'b01, 2'b00, 1, 0, "R6 R10 late-use stall");
    step(1, C_ALU,  7, 4, 10,  0, 0, 2'b10, 2'b00, 0, 1, "R9 R10 bubble and ex2 flag");
    step(1, C_STORE,10, 5, 0,  0, 0, 2'b01, 2'b00, 0, 0, "R5 store base");
    step(1, C_ALU,  1, 2, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R2 rd zero");
    step(1, C_ALU,  0, 0, 3,   0, 0, 2'b00, 2'b00, 0, 0, "R7 register 0 source");
    step(1, C_ALUI, 0, 3, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R3 immediate rt unread");
    step(1, C_ALUI, 0, 3, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R2 immediate writes rt");
    step(1, C_ALUI, 0, 3, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R2 immediate writes rt");
    step(1, C_JR,   3, 0, 0,   0, 0, 2'b01, 2'b00, 0, 0, "R8 youngest of three");
    step(0, C_JR,   3, 3, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R11 idle");
    step(1, C_BRZ,  3, 0, 0,   0, 0, 2'b11, 2'b00, 0, 0, "R8 write-back path");
    step(1, C_JAL,  3, 3, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R3 jal reads nothing");
    step(1, C_ALU, 31, 31, 6,  0, 1, 2'b01, 2'b01, 0, 0, "R2 R4 link register");
    step(1, C_STORE,2, 6, 0,   1, 0, 2'b00, 2'b01, 1, 0, "R6 store data stall");
    step(1, C_STORE,2, 6, 0,   0, 0, 2'b00, 2'b10, 0, 1, "R7 R9 stage-4 path");
    step(1, C_LOAD, 0, 0, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R2 load to r0");
    step(1, C_ALU,  0, 0, 8,   0, 0, 2'b00, 2'b00, 0, 0, "R7 no stall behind r0 load");
    step(0, C_NONE, 0, 0, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R11 drain");
    step(0, C_NONE, 0, 0, 0,   0, 0, 2'b00, 2'b00, 0, 0, "R11 drain");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule